// File: doc/BRIEF.md
# Pin Function and GPIO Controller

This block is a register-mapped controller for a set of 8-pin ports. Software reaches it through a plain single-cycle register bus. For every pin the block holds a 2-bit direction field, an output data bit, a mode bit and a function-select byte. It also shows a synchronised copy of the pad level. From these it drives the pad output and the pad output enable, and it hands the pad to a peripheral when the pin is in peripheral mode.

The function-select bytes are guarded by a small write-protect register. It has a write-disable bit (bit 7) and a select-write-enable bit (bit 6). The enable bit can only be changed while the disable bit is clear, so opening the function-select bytes takes two writes in a set order. Closing them again also takes two writes. After reset every pin is in the Hi-Z non-use state with the protection closed.

Top module: `pinctl_top`

## Requirements
- R1: After reset the protect register reads 0x80, and every direction, output data, mode and function-select field reads 0. All pad output enables are low.
- R2: The direction halfword of port p is at 0x000+2p, with bits [2n+1:2n] for pin n. In GPIO mode, pad_oe of a pin is high only when its field is 11; the codes 10 (input), 00 (Hi-Z non-use) and 01 keep it low.
- R3: The output data byte of port p is at 0x040+p. In GPIO mode, bit n drives pad_out of pin n.
- R4: The input data byte of port p at 0x060+p returns the pad level two clock edges after the pad changes. A pin in GPIO mode whose direction field has bit 1 clear reads 0 there.
- R5: The mode byte of port p is at 0x080+p. When bit n is 1, pad_out and pad_oe of pin n follow periph_o and periph_oe, and periph_in equals pad_in. When bit n is 0, periph_in of that pin is 0.
- R6: The protect register at 0x2FF reads bit 7 and bit 6 in those positions, with every other bit 0. A write always loads bit 7. Bit 6 takes the written value only if bit 7 was 0 before that write.
- R7: The function-select byte of pin n of port p is at 0x200+8p+n and appears on pin_func[8i+7:8i]. A write to it is ignored while protect bit 6 is 0.
- R8: Writing 0x00 and then 0x40 to the protect register opens the function-select bytes. Writing 0x00 and then 0x80 closes them. A single 0x40 written while bit 7 is set leaves bit 6 at 0.
- R9: Reads of addresses that map to no register return 0, and writes to them change no register.
- R10: Pin ID i = 8p+n selects port p = i/8 and pin n = i%8, and it is bit i of every per-pin port vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data: halfword for direction, bits [7:0] otherwise |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pad_in | input | 8*NUM_PORTS | Pad input levels |
| pad_out | output | 8*NUM_PORTS | Pad output levels |
| pad_oe | output | 8*NUM_PORTS | Pad output enables |
| periph_o | input | 8*NUM_PORTS | Peripheral output per pin |
| periph_oe | input | 8*NUM_PORTS | Peripheral output enable per pin |
| periph_in | output | 8*NUM_PORTS | Pad level given to the peripheral |
| pin_func | output | 64*NUM_PORTS | Function-select byte per pin |

## Verification
The hardest state to reach is the open protect state. Bit 6 can only be set after an earlier write has cleared bit 7, so random byte writes to 0x2FF seldom open it and seldom close it again. The random stream therefore draws protect writes from the four values 0x00, 0x40, 0x80 and 0xC0, so every sequence of lock steps occurs many times between function-select writes. Directed cases also cover a lone 0x40 written while bit 7 is set, and a select write made while the protection is closed.

// File: rtl/pinctl_pkg.sv
// Shared constants for the pin controller: register base addresses,
// pins per port and the direction field codes. Assumes a 12-bit byte address.
package pinctl_pkg;
    localparam int          PINS_PER_PORT = 8;
    localparam int          ADDR_W        = 12;
    localparam logic [11:0] DIR_BASE      = 12'h000;
    localparam logic [11:0] ODR_BASE      = 12'h040;
    localparam logic [11:0] IDR_BASE      = 12'h060;
    localparam logic [11:0] MODE_BASE     = 12'h080;
    localparam logic [11:0] FSEL_BASE     = 12'h200;
    localparam logic [11:0] WPROT_ADDR    = 12'h2FF;

    typedef enum logic [1:0] {
        DIR_HIZ  = 2'b00,
        DIR_RSVD = 2'b01,
        DIR_IN   = 2'b10,
        DIR_OUT  = 2'b11
    } pin_dir_e;
endpackage

// File: rtl/pinctl_wprot.sv
// Write-protect state for the function-select bytes.
// lock_q is the write-disable bit and fsel_we_q the select-write enable.
// Assumes wr_en is a single-cycle strobe for the protect address.
module pinctl_wprot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wbits,
    output logic       lock_q,
    output logic       fsel_we_q
);
    // Bit 7 always loads; bit 6 loads only while bit 7 was clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q    <= 1'b1;
            fsel_we_q <= 1'b0;
        end else if (wr_en) begin
            lock_q <= wbits[1];
            if (!lock_q) fsel_we_q <= wbits[0];
        end
    end
endmodule

// File: rtl/pinctl_sync.sv
// Two-flop synchronizer for W independent asynchronous inputs.
// Assumes each bit is unrelated to the others (no bus coherency).
module pinctl_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages towards the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pinctl_port.sv
// One 8-pin port: direction, output data, mode and function-select registers,
// the gated and synchronised input sample, and the pad mux.
// Assumes the top decodes addresses and qualifies select writes with protection.
module pinctl_port
    import pinctl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_dir,
    input  logic                       wr_odr,
    input  logic                       wr_mode,
    input  logic [PINS_PER_PORT-1:0]   wr_fsel,
    input  logic [15:0]                wdata,
    input  logic [PINS_PER_PORT-1:0]   pad_in,
    input  logic [PINS_PER_PORT-1:0]   periph_o,
    input  logic [PINS_PER_PORT-1:0]   periph_oe,
    output logic [2*PINS_PER_PORT-1:0] dir_q,
    output logic [PINS_PER_PORT-1:0]   odr_q,
    output logic [PINS_PER_PORT-1:0]   idr_q,
    output logic [PINS_PER_PORT-1:0]   mode_q,
    output logic [8*PINS_PER_PORT-1:0] fsel_q,
    output logic [PINS_PER_PORT-1:0]   pad_out,
    output logic [PINS_PER_PORT-1:0]   pad_oe,
    output logic [PINS_PER_PORT-1:0]   periph_in
);
    logic [PINS_PER_PORT-1:0] in_gated;

    // Direction, output data and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            odr_q  <= '0;
            mode_q <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wdata;
            if (wr_odr)  odr_q  <= wdata[7:0];
            if (wr_mode) mode_q <= wdata[7:0];
        end
    end

    for (genvar n = 0; n < PINS_PER_PORT; n++) begin : g_pin
        // Function-select byte of this pin.
        always_ff @(posedge clk) begin
            if (!rst_n)          fsel_q[8*n +: 8] <= 8'h00;
            else if (wr_fsel[n]) fsel_q[8*n +: 8] <= wdata[7:0];
        end

        // Pad mux: peripheral path in mode 1, GPIO registers in mode 0.
        always_comb begin
            in_gated[n]  = pad_in[n] & (mode_q[n] | dir_q[2*n+1]);
            periph_in[n] = pad_in[n] & mode_q[n];
            if (mode_q[n]) begin
                pad_out[n] = periph_o[n];
                pad_oe[n]  = periph_oe[n];
            end else begin
                pad_out[n] = odr_q[n];
                pad_oe[n]  = (dir_q[2*n +: 2] == DIR_OUT);
            end
        end
    end

    pinctl_sync #(.W(PINS_PER_PORT)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (in_gated),
        .q    (idr_q)
    );
endmodule

// File: rtl/pinctl_top.sv
// Pin function and GPIO controller for NUM_PORTS ports of 8 pins.
// Decodes the register bus, holds the protect state and one register set per port.
// Assumes NUM_PORTS <= 31 so the select bytes stay below the protect address.
module pinctl_top
    import pinctl_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int NP = NUM_PORTS * PINS_PER_PORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [NP-1:0]     pad_in,
    output logic [NP-1:0]     pad_out,
    output logic [NP-1:0]     pad_oe,
    input  logic [NP-1:0]     periph_o,
    input  logic [NP-1:0]     periph_oe,
    output logic [NP-1:0]     periph_in,
    output logic [8*NP-1:0]   pin_func
);
    logic            wp_lock, wp_fwe;
    logic [2*NP-1:0] dir_all;
    logic [NP-1:0]   odr_all, idr_all, mode_all;

    pinctl_wprot u_wprot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we && bus_addr == WPROT_ADDR),
        .wbits    (bus_wdata[7:6]),
        .lock_q   (wp_lock),
        .fsel_we_q(wp_fwe)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [11:0] A_DIR  = DIR_BASE  + 12'(2*p);
        localparam logic [11:0] A_ODR  = ODR_BASE  + 12'(p);
        localparam logic [11:0] A_MODE = MODE_BASE + 12'(p);
        logic [PINS_PER_PORT-1:0] fsel_wr;

        // Select writes pass only while the protect enable bit is set.
        always_comb begin
            for (int n = 0; n < PINS_PER_PORT; n++)
                fsel_wr[n] = bus_we && wp_fwe &&
                             bus_addr == FSEL_BASE + 12'(8*p + n);
        end

        pinctl_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_dir   (bus_we && bus_addr == A_DIR),
            .wr_odr   (bus_we && bus_addr == A_ODR),
            .wr_mode  (bus_we && bus_addr == A_MODE),
            .wr_fsel  (fsel_wr),
            .wdata    (bus_wdata),
            .pad_in   (pad_in   [8*p +: 8]),
            .periph_o (periph_o [8*p +: 8]),
            .periph_oe(periph_oe[8*p +: 8]),
            .dir_q    (dir_all  [16*p +: 16]),
            .odr_q    (odr_all  [8*p +: 8]),
            .idr_q    (idr_all  [8*p +: 8]),
            .mode_q   (mode_all [8*p +: 8]),
            .fsel_q   (pin_func [64*p +: 64]),
            .pad_out  (pad_out  [8*p +: 8]),
            .pad_oe   (pad_oe   [8*p +: 8]),
            .periph_in(periph_in[8*p +: 8])
        );
    end

    // Read mux: one matching register or zero for unmapped addresses.
    always_comb begin
        bus_rdata = 16'h0000;
        if (bus_addr == WPROT_ADDR) bus_rdata = {8'h00, wp_lock, wp_fwe, 6'b0};
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == DIR_BASE  + 12'(2*p)) bus_rdata = dir_all[16*p +: 16];
            if (bus_addr == ODR_BASE  + 12'(p))   bus_rdata = {8'h00, odr_all[8*p +: 8]};
            if (bus_addr == IDR_BASE  + 12'(p))   bus_rdata = {8'h00, idr_all[8*p +: 8]};
            if (bus_addr == MODE_BASE + 12'(p))   bus_rdata = {8'h00, mode_all[8*p +: 8]};
            for (int n = 0; n < PINS_PER_PORT; n++)
                if (bus_addr == FSEL_BASE + 12'(8*p + n))
                    bus_rdata = {8'h00, pin_func[64*p + 8*n +: 8]};
        end
    end
endmodule

// File: rtl/pinctl_sva.sv
// Assertion checker for pinctl_top, attached by the bind below.
// Assumes the same NUM_PORTS as the bound instance.
module pinctl_sva #(
    parameter int NUM_PORTS = 4,
    localparam int NP = NUM_PORTS * 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wp_lock,
    input logic            wp_fwe,
    input logic [2*NP-1:0] dir_all,
    input logic [NP-1:0]   mode_all,
    input logic [NP-1:0]   pad_oe,
    input logic [NP-1:0]   periph_in,
    input logic [8*NP-1:0] pin_func
);
    AST_FWE_HELD_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wp_lock |=> $stable(wp_fwe)); // R6

    AST_FSEL_FROZEN_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_fwe |=> $stable(pin_func)); // R7

    for (genvar i = 0; i < NP; i++) begin : g_pin
        AST_OE_ONLY_GPIO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_all[i] && dir_all[2*i +: 2] != 2'b11) |-> !pad_oe[i]); // R2

        AST_PERIPH_IN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_all[i] |-> !periph_in[i]); // R5
    end
endmodule

bind pinctl_top pinctl_sva #(.NUM_PORTS(NUM_PORTS)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_lock  (wp_lock),
    .wp_fwe   (wp_fwe),
    .dir_all  (dir_all),
    .mode_all (mode_all),
    .pad_oe   (pad_oe),
    .periph_in(periph_in),
    .pin_func (pin_func)
);

// File: tb/test_pinctl_top.sv
// Bench for pinctl_top: directed protect and mapping cases, then random
// register and pad traffic compared against a register model in the bench.
module test_pinctl_top;
    localparam int NPORT = 4;
    localparam int NP = NPORT * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic [NP-1:0]   pad_in = '0, periph_o = '0, periph_oe = '0;
    logic [NP-1:0]   pad_out, pad_oe, periph_in;
    logic [8*NP-1:0] pin_func;

    int total = 0, bad = 0;

    // Bench model of the register state.
    logic [15:0] m_dir  [NPORT];
    logic [7:0]  m_odr  [NPORT];
    logic [7:0]  m_mode [NPORT];
    logic [7:0]  m_fsel [NP];
    logic        m_b7, m_b6;

    always #5 clk = ~clk;

    pinctl_top #(.NUM_PORTS(NPORT)) i_pinctl_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .periph_o(periph_o),
        .periph_oe(periph_oe), .periph_in(periph_in), .pin_func(pin_func)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        // Model update
        if (a == 12'h2FF) begin
            if (!m_b7) m_b6 = d[6];
            m_b7 = d[7];
        end
        for (int p = 0; p < NPORT; p++) begin
            if (a == 12'(2*p))          m_dir[p]  = d;
            if (a == 12'h040 + 12'(p))  m_odr[p]  = d[7:0];
            if (a == 12'h080 + 12'(p))  m_mode[p] = d[7:0];
        end
        for (int i = 0; i < NP; i++)
            if (a == 12'h200 + 12'(i) && m_b6) m_fsel[i] = d[7:0];
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++)
            v[i] = m_mode[i/8][i%8] ? periph_oe[i] : (m_dir[i/8][2*(i%8) +: 2] == 2'b11);
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++)
            v[i] = m_mode[i/8][i%8] ? periph_o[i] : m_odr[i/8][i%8];
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_pin();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = pad_in[i] & m_mode[i/8][i%8];
        return v;
    endfunction

    function automatic logic [7:0] exp_idr(input int p);
        logic [7:0] v;
        for (int n = 0; n < 8; n++)
            v[n] = pad_in[8*p+n] & (m_mode[p][n] | m_dir[p][2*n+1]);
        return v;
    endfunction

    function automatic logic [8*NP-1:0] exp_func();
        logic [8*NP-1:0] v;
        for (int i = 0; i < NP; i++) v[8*i +: 8] = m_fsel[i];
        return v;
    endfunction

    // Full comparison of readable state and pad outputs against the model.
    task automatic compare_all(input string tag);
        logic [15:0] d;
        repeat (3) @(negedge clk);
        for (int p = 0; p < NPORT; p++) begin
            rd(12'(2*p), d);           chk({tag, " R2 dir"},  d, m_dir[p]);
            rd(12'h040 + 12'(p), d);   chk({tag, " R3 odr"},  d, {8'h0, m_odr[p]});
            rd(12'h080 + 12'(p), d);   chk({tag, " R5 mode"}, d, {8'h0, m_mode[p]});
            rd(12'h060 + 12'(p), d);   chk({tag, " R4 idr"},  d, {8'h0, exp_idr(p)});
        end
        rd(12'h2FF, d);                chk({tag, " R6 wprot"}, d, {8'h0, m_b7, m_b6, 6'b0});
        chk({tag, " R2 pad_oe"}, pad_oe, exp_oe());
        chk({tag, " R3 pad_out"}, pad_out, exp_out());
        chk({tag, " R5 periph_in"}, periph_in, exp_pin());
        chk({tag, " R7 pin_func"}, pin_func[63:0], exp_func() & 64'hFFFF_FFFF_FFFF_FFFF);
        chk({tag, " R7 pin_func hi"}, pin_func[8*NP-1:64], exp_func() >> 64);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'h5EED));
        for (int p = 0; p < NPORT; p++) begin m_dir[p] = 0; m_odr[p] = 0; m_mode[p] = 0; end
        for (int i = 0; i < NP; i++) m_fsel[i] = 0;
        m_b7 = 1'b1; m_b6 = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(12'h2FF, d); chk("R1 wprot reset", d, 16'h0080);
        chk("R1 pad_oe reset", pad_oe, '0);
        chk("R1 pin_func reset", pin_func[63:0], 64'h0);
        compare_all("R1 reset");

        // R8: a lone 0x40 while locked clears bit 7 but leaves bit 6 low
        wr(12'h2FF, 16'h0040);
        rd(12'h2FF, d); chk("R8 lone 0x40", d, 16'h0000);
        // R7: select write ignored while closed
        wr(12'h20A, 16'h0015);
        chk("R7 ignored while closed", pin_func[87:80], 8'h00);
        rd(12'h20A, d); chk("R7 readback closed", d, 16'h0000);
        // R8: unlock completes
        wr(12'h2FF, 16'h0040);
        rd(12'h2FF, d); chk("R8 unlocked", d, 16'h0040);
        wr(12'h20A, 16'h0015);
        chk("R7 write when open", pin_func[87:80], 8'h15);
        // R8: relock
        wr(12'h2FF, 16'h0000);
        wr(12'h2FF, 16'h0080);
        rd(12'h2FF, d); chk("R8 relocked", d, 16'h0080);
        wr(12'h20A, 16'h0033);
        chk("R7 ignored after relock", pin_func[87:80], 8'h15);

        // R10: pin 21 = port 2 pin 5, driven as GPIO output high
        wr(12'h004, 16'h0C00);
        wr(12'h042, 16'h0020);
        @(negedge clk);
        chk("R10 pad_oe pin 21", pad_oe, 32'h0020_0000);
        chk("R10 pad_out pin 21", pad_out, 32'h0020_0000);

        // R4: Hi-Z pin reads 0; input pin reads pad after sync
        pad_in = '1;
        repeat (3) @(negedge clk);
        rd(12'h060, d); chk("R4 hiz gated", d, 16'h0000);
        rd(12'h062, d); chk("R4 output pin sampled", d, 16'h0020);

        // R9: unmapped read zero, unmapped write no effect
        rd(12'h0A0, d); chk("R9 unmapped read", d, 16'h0000);
        rd(12'h3F0, d); chk("R9 unmapped read high", d, 16'h0000);
        wr(12'h0A0, 16'hFFFF);
        wr(12'h008, 16'hFFFF);
        compare_all("R9 after unmapped writes");

        // Random traffic mixed with protect sequences
        for (int k = 0; k < 300; k++) begin
            int kind;
            int p;
            kind = $urandom_range(0, 6);
            p = $urandom_range(0, NPORT - 1);
            case (kind)
                0: wr(12'(2*p), 16'($urandom));
                1: wr(12'h040 + 12'(p), 16'($urandom_range(0, 255)));
                2: wr(12'h080 + 12'(p), 16'($urandom_range(0, 255)));
                3: wr(12'h200 + 12'($urandom_range(0, NP - 1)), 16'($urandom_range(0, 255)));
                4: wr(12'h2FF, 16'(($urandom_range(0, 3)) << 6));
                5: begin
                    @(negedge clk);
                    pad_in = NP'($urandom);
                end
                default: begin
                    @(negedge clk);
                    periph_o  = NP'($urandom);
                    periph_oe = NP'($urandom);
                end
            endcase
            compare_all("random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule